// File: doc/BRIEF.md
# Prebiased Startup Sequencer

This block sequences the start of a synchronous step-down converter whose output capacitor may already hold charge. It keeps both power switches off after enable. It then hands the converter to the normal PWM loop, or it first runs a forced-start mode that can pull an output sitting above its setpoint back down without a sudden discharge. Its inputs are comparator flags that are already synchronous to the clock: soft-start has crossed feedback, soft-start has reached the forced-start level, low-side reverse (sink) current limit, high-side reduced current limit, and a one-cycle tick at the start of each switching period.

In forced-start mode each switching period opens with the low-side switch on. The low side is cut early when the sink current limit trips. The high side then conducts until the reduced high-side limit trips or the period ends. After a trip the high side stays off for the rest of that period. The switch commands pass through a dead-time stage, so the two switches are never on together. In normal mode this block drives both switch commands low and signals through its mode output that the main PWM logic owns the switches.

Top module: `prebias_start_seq`

## Requirements
- R1: During and directly after synchronous reset, mode is 0 (idle), and hs_on, ls_on and handover are all 0.
- R2: A low en at a clock edge puts mode at 0 (idle) after that edge, from any state. Both switch outputs are 0 one edge later.
- R3: From idle with en high, mode becomes 1 (hold-off) after the next edge. While mode is 1, hs_on and ls_on stay 0.
- R4: In hold-off, ss_cross_fb takes mode to 3 (normal) after the next edge. This holds even when ss_forced_lvl is high in the same cycle, and no handover pulse is raised.
- R5: In hold-off, ss_forced_lvl with ss_cross_fb low takes mode to 2 (forced) after the next edge.
- R6: In forced mode, a cyc_tick starts a period with the low side requested. ls_on rises one edge after the tick is sampled, provided the dead time has already elapsed.
- R7: In forced mode, ls_sink_lim during the low-side phase drops ls_on one edge later. hs_on rises DEAD_CYC edges after ls_on drops.
- R8: In forced mode, hs_red_lim during the high-side phase drops hs_on one edge later. Both switches then stay off until the next cyc_tick. A cyc_tick during the high-side phase also ends it and begins a new low-side phase.
- R9: When cyc_tick and a current-limit flag are sampled at the same edge, the tick wins and the new period starts in its low-side phase.
- R10: In forced mode, ss_cross_fb takes mode to 3 after the next edge and raises handover for exactly one cycle. From one edge after that, both switch outputs are 0 for as long as mode is 3.
- R11: hs_on and ls_on are never 1 together. Each rises only after at least DEAD_CYC consecutive cycles with both at 0 (DEAD_CYC defaults to 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Converter enable |
| cyc_tick | input | 1 | One-cycle pulse at the start of each switching period |
| ss_cross_fb | input | 1 | Soft-start voltage is above feedback |
| ss_forced_lvl | input | 1 | Soft-start voltage has reached the forced-start level |
| ls_sink_lim | input | 1 | Low-side reverse (sink) current limit tripped |
| hs_red_lim | input | 1 | High-side reduced current limit tripped |
| hs_on | output | 1 | High-side switch command |
| ls_on | output | 1 | Low-side switch command |
| mode | output | 2 | 0 idle, 1 hold-off, 2 forced, 3 normal |
| handover | output | 1 | One-cycle pulse on the move from forced to normal |

## Verification
The period tick and a current-limit flag can land in the same cycle. The sequencer must then choose between ending the present phase and starting a new period. The bench provokes this twice: once with the sink limit during the low-side phase, and once with the reduced high-side limit during the high-side phase. In both cases the judgement is that the low side is on after the dead time and the high side stays off. A wrong priority would leave the low side dropped or no switch on at all.

// File: rtl/pbs_pkg.sv
package pbs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_HOLD   = 2'd1,
    ST_FORCED = 2'd2,
    ST_NORMAL = 2'd3
  } seq_state_e;

  typedef enum logic [1:0] {
    PH_OFF  = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_e;
endpackage

// File: rtl/pbs_mode_fsm.sv
module pbs_mode_fsm
  import pbs_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       ss_cross_fb,
  input  logic       ss_forced_lvl,
  output seq_state_e state,
  output logic       handover
);
  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      handover <= 1'b0;
    end else begin
      handover <= 1'b0;
      if (!en) begin
        state <= ST_IDLE;
      end else begin
        case (state)
          ST_IDLE: state <= ST_HOLD;
          ST_HOLD: begin
            if (ss_cross_fb)        state <= ST_NORMAL;
            else if (ss_forced_lvl) state <= ST_FORCED;
          end
          ST_FORCED: begin
            if (ss_cross_fb) begin
              state    <= ST_NORMAL;
              handover <= 1'b1;
            end
          end
          default: state <= ST_NORMAL;
        endcase
      end
    end
  end
endmodule

// File: rtl/pbs_phase.sv
module pbs_phase
  import pbs_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic cyc_tick,
  input  logic ls_sink_lim,
  input  logic hs_red_lim,
  output logic want_hs,
  output logic want_ls
);
  phase_e phase;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      phase <= PH_OFF;
    end else if (cyc_tick) begin
      // a new period outranks any limit flag seen in the same cycle
      phase <= PH_LOW;
    end else begin
      case (phase)
        PH_LOW:  if (ls_sink_lim) phase <= PH_HIGH;
        PH_HIGH: if (hs_red_lim)  phase <= PH_OFF;
        default: phase <= phase;
      endcase
    end
  end

  assign want_hs = (phase == PH_HIGH);
  assign want_ls = (phase == PH_LOW);
endmodule

// File: rtl/pbs_deadtime.sv
module pbs_deadtime #(
  parameter int DEAD_CYC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic want_hs,
  input  logic want_ls,
  output logic hs_on,
  output logic ls_on
);
  localparam int CW = $clog2(DEAD_CYC + 1);
  localparam logic [CW-1:0] DEAD_V = CW'(DEAD_CYC);

  logic [CW-1:0] off_cnt;
  logic          hs_n, ls_n;
  logic          gap_ok;

  assign gap_ok = (off_cnt == DEAD_V);
  assign hs_n   = want_hs && (hs_on || (!ls_on && gap_ok));
  assign ls_n   = want_ls && (ls_on || (!hs_on && gap_ok));

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_on   <= 1'b0;
      ls_on   <= 1'b0;
      off_cnt <= DEAD_V;
    end else begin
      hs_on <= hs_n;
      ls_on <= ls_n;
      if (hs_n || ls_n)  off_cnt <= '0;
      else if (!gap_ok)  off_cnt <= off_cnt + CW'(1);
    end
  end
endmodule

// File: rtl/prebias_start_seq.sv
module prebias_start_seq
  import pbs_pkg::*;
#(
  parameter int DEAD_CYC = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       cyc_tick,
  input  logic       ss_cross_fb,
  input  logic       ss_forced_lvl,
  input  logic       ls_sink_lim,
  input  logic       hs_red_lim,
  output logic       hs_on,
  output logic       ls_on,
  output logic [1:0] mode,
  output logic       handover
);
  seq_state_e state;
  logic       run, want_hs, want_ls;

  pbs_mode_fsm u_fsm (
    .clk(clk), .rst(rst), .en(en), .ss_cross_fb(ss_cross_fb),
    .ss_forced_lvl(ss_forced_lvl), .state(state), .handover(handover)
  );

  assign run = en && (state == ST_FORCED) && !ss_cross_fb;

  pbs_phase u_phase (
    .clk(clk), .rst(rst), .run(run), .cyc_tick(cyc_tick),
    .ls_sink_lim(ls_sink_lim), .hs_red_lim(hs_red_lim),
    .want_hs(want_hs), .want_ls(want_ls)
  );

  pbs_deadtime #(.DEAD_CYC(DEAD_CYC)) u_dt (
    .clk(clk), .rst(rst), .want_hs(want_hs), .want_ls(want_ls),
    .hs_on(hs_on), .ls_on(ls_on)
  );

  assign mode = state;
endmodule

// File: rtl/pbs_chk.sv
module pbs_chk #(
  parameter int DEAD_CYC = 2
) (
  input logic       clk,
  input logic       rst,
  input logic       en,
  input logic       ss_cross_fb,
  input logic       ss_forced_lvl,
  input logic       hs_on,
  input logic       ls_on,
  input logic [1:0] mode,
  input logic       handover
);
  localparam int CW = $clog2(DEAD_CYC + 1);
  localparam logic [CW-1:0] DEAD_V = CW'(DEAD_CYC);

  logic [CW-1:0] gap;
  always_ff @(posedge clk) begin
    if (rst)                gap <= DEAD_V;
    else if (hs_on || ls_on) gap <= '0;
    else if (gap != DEAD_V) gap <= gap + CW'(1);
  end

  a_r11_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(hs_on && ls_on));
  a_r11_hs_gap: assert property (@(posedge clk) disable iff (rst)
    $rose(hs_on) |-> (gap == DEAD_V));
  a_r11_ls_gap: assert property (@(posedge clk) disable iff (rst)
    $rose(ls_on) |-> (gap == DEAD_V));
  a_r2_idle_on_disable: assert property (@(posedge clk) disable iff (rst)
    !en |=> (mode == 2'd0));
  a_r3_hold_off_quiet: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd1) |-> (!hs_on && !ls_on));
  a_r4_cross_priority: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd1 && en && ss_cross_fb) |=> (mode == 2'd3 && !handover));
  a_r5_forced_entry: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd1 && en && !ss_cross_fb && ss_forced_lvl) |=> (mode == 2'd2));
  a_r10_handover_src: assert property (@(posedge clk) disable iff (rst)
    handover |-> (mode == 2'd3 && $past(mode) == 2'd2));
  a_r10_handover_pulse: assert property (@(posedge clk) disable iff (rst)
    handover |=> !handover);
  a_r10_normal_quiet: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd3 && $past(mode) == 2'd3) |-> (!hs_on && !ls_on));
endmodule

bind prebias_start_seq pbs_chk #(.DEAD_CYC(DEAD_CYC)) u_pbs_chk (
  .clk(clk), .rst(rst), .en(en), .ss_cross_fb(ss_cross_fb),
  .ss_forced_lvl(ss_forced_lvl), .hs_on(hs_on), .ls_on(ls_on),
  .mode(mode), .handover(handover)
);

// File: tb/test_prebias_start_seq.sv
module test_prebias_start_seq;
  logic clk = 1'b0;
  logic rst, en, cyc_tick, ss_cross_fb, ss_forced_lvl, ls_sink_lim, hs_red_lim;
  logic hs_on, ls_on, handover;
  logic [1:0] mode;
  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  prebias_start_seq #(.DEAD_CYC(2)) i_prebias_start_seq (
    .clk(clk), .rst(rst), .en(en), .cyc_tick(cyc_tick),
    .ss_cross_fb(ss_cross_fb), .ss_forced_lvl(ss_forced_lvl),
    .ls_sink_lim(ls_sink_lim), .hs_red_lim(hs_red_lim),
    .hs_on(hs_on), .ls_on(ls_on), .mode(mode), .handover(handover)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic pulse_tick();
    cyc_tick = 1'b1; edges(1); cyc_tick = 1'b0;
  endtask

  // bring the block into forced mode with both switches off
  task automatic enter_forced();
    en = 1'b0; edges(2);
    en = 1'b1; edges(1);
    ss_forced_lvl = 1'b1; edges(1); ss_forced_lvl = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1; en = 1'b0; cyc_tick = 1'b0; ss_cross_fb = 1'b0;
    ss_forced_lvl = 1'b0; ls_sink_lim = 1'b0; hs_red_lim = 1'b0;
    edges(3);
    chk("R1 mode", mode, 0); chk("R1 hs", hs_on, 0);
    chk("R1 ls", ls_on, 0);  chk("R1 handover", handover, 0);
    rst = 1'b0; edges(1);
    chk("R1 mode after release", mode, 0);
  endtask

  task automatic t_hold_and_priority();
    en = 1'b1; edges(1);
    chk("R3 hold-off entry", mode, 1);
    pulse_tick(); edges(2);
    chk("R3 hold hs", hs_on, 0); chk("R3 hold ls", ls_on, 0);
    chk("R3 still hold", mode, 1);
    ss_cross_fb = 1'b1; ss_forced_lvl = 1'b1; edges(1);
    ss_cross_fb = 1'b0; ss_forced_lvl = 1'b0;
    chk("R4 cross beats forced", mode, 3);
    chk("R4 no handover", handover, 0);
    en = 1'b0; edges(1);
    chk("R2 normal to idle", mode, 0);
  endtask

  task automatic t_forced_cycle();
    enter_forced();
    chk("R5 forced entry", mode, 2);
    chk("R6 off before tick", ls_on, 0);
    pulse_tick();
    chk("R6 ls not yet", ls_on, 0);
    edges(1);
    chk("R6 ls on", ls_on, 1); chk("R6 hs off", hs_on, 0);
    ls_sink_lim = 1'b1; edges(1); ls_sink_lim = 1'b0;
    chk("R7 ls held one edge", ls_on, 1);
    edges(1);
    chk("R7 ls cut", ls_on, 0); chk("R11 gap hs 1", hs_on, 0);
    edges(1);
    chk("R11 gap hs 2", hs_on, 0);
    edges(1);
    chk("R7 hs on after dead time", hs_on, 1);
    hs_red_lim = 1'b1; edges(1); hs_red_lim = 1'b0;
    edges(1);
    chk("R8 hs cut", hs_on, 0);
    edges(4);
    chk("R8 hs stays off", hs_on, 0); chk("R8 ls stays off", ls_on, 0);
    pulse_tick(); edges(1);
    chk("R8 next period ls", ls_on, 1);
  endtask

  task automatic t_coincide();
    // low phase, ls on: tick with sink limit in same cycle
    cyc_tick = 1'b1; ls_sink_lim = 1'b1; edges(1);
    cyc_tick = 1'b0; ls_sink_lim = 1'b0;
    edges(3);
    chk("R9 tick beats sink limit ls", ls_on, 1);
    chk("R9 tick beats sink limit hs", hs_on, 0);
    // move to high phase
    ls_sink_lim = 1'b1; edges(1); ls_sink_lim = 1'b0;
    edges(3);
    chk("R7 hs on again", hs_on, 1);
    cyc_tick = 1'b1; hs_red_lim = 1'b1; edges(1);
    cyc_tick = 1'b0; hs_red_lim = 1'b0;
    edges(1);
    chk("R8 tick ends high phase", hs_on, 0);
    edges(2);
    chk("R9 tick beats reduced limit ls", ls_on, 1);
    chk("R9 tick beats reduced limit hs", hs_on, 0);
  endtask

  task automatic t_handover();
    ss_cross_fb = 1'b1; edges(1);
    chk("R10 normal entry", mode, 3);
    chk("R10 handover raised", handover, 1);
    edges(1);
    chk("R10 handover one cycle", handover, 0);
    chk("R10 ls off", ls_on, 0); chk("R10 hs off", hs_on, 0);
    edges(3);
    ss_cross_fb = 1'b0;
    chk("R10 still normal", mode, 3);
    chk("R10 no second pulse", handover, 0);
  endtask

  task automatic t_disable_in_forced();
    enter_forced();
    pulse_tick(); edges(1);
    chk("R6 ls on again", ls_on, 1);
    en = 1'b0; edges(1);
    chk("R2 forced to idle", mode, 0);
    edges(1);
    chk("R2 switches off", ls_on, 0);
    chk("R2 hs off", hs_on, 0);
  endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_hold_and_priority();
    t_forced_cycle();
    t_coincide();
    t_handover();
    t_disable_in_forced();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule